// File: doc/BRIEF.md
# Load-linked / store-conditional reservation table

This block sits beside a core's data-cache controller and remembers the addresses for which a load-linked has been issued. It lets a later store-conditional fail at once, without a trip over the interconnect, when its reservation is gone. Each entry keeps a physical address, the registration key sent back by memory with the load-linked response, an age counter and a valid bit. A separate pending bit marks an entry whose load-linked has gone out and whose key has not yet come back.

The controller presents exactly one command in every cycle. When it has nothing else to present it sends a no-op, so the age counters keep moving. The table answers in the same cycle, combinationally, with a done flag, a hit flag, the stored key and an entry index. A load-linked request that returns done low must be dropped and retried later. A store-conditional that misses is a local failure, which the controller reports to the core as the value 1. On a hit, the key goes out with the store-conditional command. Every plain store, including page-table flag updates made by compare-and-swap, is also presented, so that it can cancel a matching reservation.

Top module: `llsc_resv_table`

## Requirements
- R1: After reset no entry is valid or pending, so a store-conditional (cmdIn=3) to any address returns hit=0, keyOut=0 and entryIdx=0.
- R2: A load-linked request (cmdIn=1) picks an entry in this order: the lowest entry that is valid or pending with the same address, then the lowest entry that is neither valid nor pending, then the lowest entry that is not pending (evicting its reservation). It returns done=1 and the chosen index on entryIdx. The entry becomes pending and not valid. If every entry is pending at another address, done=0 and nothing changes.
- R3: A load-linked response (cmdIn=2) whose rspIdx names a pending entry stores rspKey there, marks the entry valid and clears pending. A response to an entry that is not pending, or to an index beyond the table, has no effect.
- R4: A store-conditional (cmdIn=3) whose address equals that of a valid entry returns hit=1, that entry's key on keyOut and its index on entryIdx, and the entry becomes invalid. With no such entry it returns hit=0 and keyOut=0. A pending entry never gives a hit.
- R5: A plain store (cmdIn=4) clears valid and pending on every entry holding the same address, so a later response for that entry has no effect. Entries holding other addresses are not changed.
- R6: After its response, an entry stays valid for exactly AGE_LIMIT command cycles, counting no-ops: a store-conditional in the AGE_LIMIT-th cycle after the response hits, and in the next cycle it misses.
- R7: The no-op (cmdIn=0), response, store-conditional and store commands always return done=1. Codes 5 to 7 act as a no-op.
- R8: Whenever no hit is reported, keyOut is 0. entryIdx is 0 for all commands except an accepted load-linked request and a store-conditional hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdIn | input | 3 | Command: 0 no-op, 1 LL request, 2 LL response, 3 SC check, 4 store |
| reqAddr | input | ADDR_W | Physical address for LL request, SC and store |
| rspKey | input | KEY_W | Registration key carried by the LL response |
| rspIdx | input | IDX_W | Entry addressed by the LL response |
| done | output | 1 | Command accepted; low asks for a retry |
| hit | output | 1 | SC found a valid reservation |
| keyOut | output | KEY_W | Key of the hit entry, else 0 |
| entryIdx | output | IDX_W | Entry chosen by an LL request or hit by an SC |

## Verification
The hardest situations to reach from the ports are the ones where several entries are busy at once. These are a load-linked refused because every entry is pending, an eviction of the lowest valid entry, and a reservation that expires in the very cycle it would otherwise hit. The stimulus sets these up with a small table and a short age limit. Directed sequences fill both entries with overlapping requests and responses, count no-ops to one cycle either side of the age limit, and kill pending entries with stores before their response arrives. A long random run over three addresses and stray response indices is then compared cycle by cycle against a behavioural model.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_LL_REQ = 3'd1,
    CMD_LL_RSP = 3'd2,
    CMD_SC     = 3'd3,
    CMD_STORE  = 3'd4
  } llscCmd_e;

  // per-entry update strobes from control to datapath
  typedef struct packed {
    logic arm;   // start a reservation at reqAddr (pending)
    logic fill;  // load key, make valid
    logic kill;  // drop valid and pending
  } entryStrobe_t;

endpackage

// File: rtl/llsc_age_counter.sv
module llsc_age_counter #(
  parameter int AGE_LIMIT = 8000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expire
);
  localparam int CNT_W = $clog2(AGE_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AGE_LIMIT - 1);

  logic [CNT_W-1:0] count;

  assign expire = run && (count == LAST);

  always_ff @(posedge clk) begin
    if (rst || restart || !run || expire) begin
      count <= '0;
    end else begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/llsc_resv_entries.sv
module llsc_resv_entries
  import llsc_pkg::*;
#(
  parameter int NUM_ENTRIES = 1,
  parameter int ADDR_W      = 32,
  parameter int KEY_W       = 32,
  parameter int AGE_LIMIT   = 8000,
  parameter int IDX_W       = 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            reqAddr,
  input  logic [KEY_W-1:0]             rspKey,
  input  entryStrobe_t [NUM_ENTRIES-1:0] strobes,
  input  logic [IDX_W-1:0]             selIdx,
  output logic [NUM_ENTRIES-1:0]       validVec,
  output logic [NUM_ENTRIES-1:0]       pendVec,
  output logic [NUM_ENTRIES-1:0]       addrEqVec,
  output logic [KEY_W-1:0]             selKey
);
  logic [KEY_W-1:0] keyArr [NUM_ENTRIES];

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : gEntry
    logic [ADDR_W-1:0] entAddr;
    logic [KEY_W-1:0]  entKey;
    logic              entValid;
    logic              entPend;
    logic              entExpire;

    llsc_age_counter #(.AGE_LIMIT(AGE_LIMIT)) uAge (
      .clk     (clk),
      .rst     (rst),
      .run     (entValid),
      .restart (strobes[g].arm | strobes[g].fill | strobes[g].kill),
      .expire  (entExpire)
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        entAddr  <= '0;
        entKey   <= '0;
        entValid <= 1'b0;
        entPend  <= 1'b0;
      end else if (strobes[g].arm) begin
        entAddr  <= reqAddr;
        entValid <= 1'b0;
        entPend  <= 1'b1;
      end else if (strobes[g].fill) begin
        entKey   <= rspKey;
        entValid <= 1'b1;
        entPend  <= 1'b0;
      end else if (strobes[g].kill) begin
        entValid <= 1'b0;
        entPend  <= 1'b0;
      end else if (entExpire) begin
        entValid <= 1'b0;
      end
    end

    assign validVec[g]  = entValid;
    assign pendVec[g]   = entPend;
    assign addrEqVec[g] = (entAddr == reqAddr);
    assign keyArr[g]    = entKey;
  end

  always_comb begin
    selKey = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (selIdx == IDX_W'(i)) selKey = keyArr[i];
    end
  end
endmodule

// File: rtl/llsc_resv_ctrl.sv
module llsc_resv_ctrl
  import llsc_pkg::*;
#(
  parameter int NUM_ENTRIES = 1,
  parameter int IDX_W       = 1
) (
  input  logic [2:0]                     cmdIn,
  input  logic [IDX_W-1:0]               rspIdx,
  input  logic [NUM_ENTRIES-1:0]         validVec,
  input  logic [NUM_ENTRIES-1:0]         pendVec,
  input  logic [NUM_ENTRIES-1:0]         addrEqVec,
  output entryStrobe_t [NUM_ENTRIES-1:0] strobes,
  output logic                           done,
  output logic                           hit,
  output logic [IDX_W-1:0]               selIdx,
  output logic [IDX_W-1:0]               entryIdx
);
  logic [NUM_ENTRIES-1:0] busyVec, liveHit, resvHit, freeVec, evictVec;
  logic             liveFound, freeFound, evictFound, scFound, llFound;
  logic [IDX_W-1:0] liveIdx, freeIdx, evictIdx, scIdx, llIdx;

  function automatic logic [IDX_W:0] lowestSet(input logic [NUM_ENTRIES-1:0] v);
    logic [IDX_W:0] r;
    r = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = {1'b1, IDX_W'(i)};
    end
    return r;
  endfunction

  assign busyVec  = validVec | pendVec;
  assign liveHit  = busyVec & addrEqVec;
  assign resvHit  = validVec & addrEqVec;
  assign freeVec  = ~busyVec;
  assign evictVec = ~pendVec;

  assign {liveFound, liveIdx}   = lowestSet(liveHit);
  assign {freeFound, freeIdx}   = lowestSet(freeVec);
  assign {evictFound, evictIdx} = lowestSet(evictVec);
  assign {scFound, scIdx}       = lowestSet(resvHit);

  always_comb begin
    llFound = 1'b1;
    if (liveFound)       llIdx = liveIdx;
    else if (freeFound)  llIdx = freeIdx;
    else if (evictFound) llIdx = evictIdx;
    else begin
      llFound = 1'b0;
      llIdx   = '0;
    end
  end

  always_comb begin
    strobes  = '0;
    done     = 1'b1;
    hit      = 1'b0;
    selIdx   = '0;
    entryIdx = '0;
    case (cmdIn)
      CMD_LL_REQ: begin
        done = llFound;
        if (llFound) begin
          entryIdx = llIdx;
          for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (llIdx == IDX_W'(i)) strobes[i].arm = 1'b1;
          end
        end
      end
      CMD_LL_RSP: begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          if (rspIdx == IDX_W'(i) && pendVec[i]) strobes[i].fill = 1'b1;
        end
      end
      CMD_SC: begin
        if (scFound) begin
          hit      = 1'b1;
          selIdx   = scIdx;
          entryIdx = scIdx;
          for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (scIdx == IDX_W'(i)) strobes[i].kill = 1'b1;
          end
        end
      end
      CMD_STORE: begin
        for (int i = 0; i < NUM_ENTRIES; i++) begin
          strobes[i].kill = liveHit[i];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/llsc_resv_table.sv
module llsc_resv_table
  import llsc_pkg::*;
#(
  parameter int NUM_ENTRIES = 1,
  parameter int ADDR_W      = 32,
  parameter int KEY_W       = 32,
  parameter int AGE_LIMIT   = 8000,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cmdIn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [KEY_W-1:0]  rspKey,
  input  logic [IDX_W-1:0]  rspIdx,
  output logic              done,
  output logic              hit,
  output logic [KEY_W-1:0]  keyOut,
  output logic [IDX_W-1:0]  entryIdx
);
  entryStrobe_t [NUM_ENTRIES-1:0] strobes;
  logic [NUM_ENTRIES-1:0] validVec, pendVec, addrEqVec;
  logic [IDX_W-1:0]       selIdx;
  logic [KEY_W-1:0]       selKey;

  llsc_resv_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) uCtrl (
    .cmdIn     (cmdIn),
    .rspIdx    (rspIdx),
    .validVec  (validVec),
    .pendVec   (pendVec),
    .addrEqVec (addrEqVec),
    .strobes   (strobes),
    .done      (done),
    .hit       (hit),
    .selIdx    (selIdx),
    .entryIdx  (entryIdx)
  );

  llsc_resv_entries #(
    .NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W), .KEY_W(KEY_W),
    .AGE_LIMIT(AGE_LIMIT), .IDX_W(IDX_W)
  ) uEntries (
    .clk       (clk),
    .rst       (rst),
    .reqAddr   (reqAddr),
    .rspKey    (rspKey),
    .strobes   (strobes),
    .selIdx    (selIdx),
    .validVec  (validVec),
    .pendVec   (pendVec),
    .addrEqVec (addrEqVec),
    .selKey    (selKey)
  );

  assign keyOut = hit ? selKey : '0;
endmodule

// File: rtl/llsc_resv_table_checker.sv
module llsc_resv_table_checker
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int KEY_W  = 32,
  parameter int IDX_W  = 1
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        cmdIn,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              done,
  input logic              hit,
  input logic [KEY_W-1:0]  keyOut,
  input logic [IDX_W-1:0]  entryIdx
);
  // first cycle after reset: nothing reserved
  a_r1_no_hit_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !hit);

  // an accepted LL request leaves the entry pending, never valid
  a_r2_pending_no_hit: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_LL_REQ && done) |=>
      !(cmdIn == CMD_SC && reqAddr == $past(reqAddr) && hit));

  // a hit consumes the reservation
  a_r4_hit_consumes: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_SC && hit) |=>
      !(cmdIn == CMD_SC && reqAddr == $past(reqAddr) && hit));

  // hits only arise from SC commands
  a_r4_hit_needs_sc: assert property (@(posedge clk) disable iff (rst)
    hit |-> cmdIn == CMD_SC);

  // a store to the address cancels it for the next cycle
  a_r5_store_cancels: assert property (@(posedge clk) disable iff (rst)
    (cmdIn == CMD_STORE) |=>
      !(cmdIn == CMD_SC && reqAddr == $past(reqAddr) && hit));

  // only LL requests may be refused
  a_r7_done_others: assert property (@(posedge clk) disable iff (rst)
    (cmdIn != CMD_LL_REQ) |-> done);

  // no key leaks without a hit
  a_r8_key_quiet: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (keyOut == '0));
endmodule

bind llsc_resv_table llsc_resv_table_checker #(
  .ADDR_W(ADDR_W), .KEY_W(KEY_W), .IDX_W(IDX_W)
) uChecker (
  .clk(clk), .rst(rst), .cmdIn(cmdIn), .reqAddr(reqAddr),
  .done(done), .hit(hit), .keyOut(keyOut), .entryIdx(entryIdx)
);

// File: tb/llsc_resv_table_test.sv
module llsc_resv_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 2;
  localparam int AW    = 32;
  localparam int KW    = 32;
  localparam int LIMIT = 12;
  localparam int IW    = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    cmdIn = 3'd0;
  logic [AW-1:0] reqAddr = '0;
  logic [KW-1:0] rspKey = '0;
  logic [IW-1:0] rspIdx = '0;
  logic          done, hit;
  logic [KW-1:0] keyOut;
  logic [IW-1:0] entryIdx;

  int compared = 0;
  int mismatched = 0;

  llsc_resv_table #(.NUM_ENTRIES(N), .ADDR_W(AW), .KEY_W(KW), .AGE_LIMIT(LIMIT)) uut (
    .clk(clk), .rst(rst), .cmdIn(cmdIn), .reqAddr(reqAddr), .rspKey(rspKey),
    .rspIdx(rspIdx), .done(done), .hit(hit), .keyOut(keyOut), .entryIdx(entryIdx)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural model state
  bit     mV [N];
  bit     mP [N];
  int     mAge [N];
  longint mA [N];
  longint mK [N];

  localparam logic [AW-1:0] A0 = 32'h0000_1000;
  localparam logic [AW-1:0] A1 = 32'h0000_2040;
  localparam logic [AW-1:0] A2 = 32'h0000_3080;

  function automatic void modelReset();
    for (int i = 0; i < N; i++) begin
      mV[i] = 0; mP[i] = 0; mAge[i] = 0; mA[i] = 0; mK[i] = 0;
    end
  endfunction

  task automatic step(input string tag, input int cmd, input logic [AW-1:0] a,
                      input logic [KW-1:0] k, input int ri);
    bit eDone, eHit;
    longint eKey;
    int eIdx;
    bit arm [N];
    bit fill [N];
    bit kill [N];
    bit expd [N];
    int pick;
    @(negedge clk);
    cmdIn = 3'(cmd); reqAddr = a; rspKey = k; rspIdx = IW'(ri);
    eDone = 1; eHit = 0; eKey = 0; eIdx = 0; pick = -1;
    for (int i = 0; i < N; i++) begin arm[i] = 0; fill[i] = 0; kill[i] = 0; end
    if (cmd == 1) begin
      for (int i = N - 1; i >= 0; i--) if ((mV[i] || mP[i]) && mA[i] == longint'(a)) pick = i;
      if (pick < 0) for (int i = N - 1; i >= 0; i--) if (!mV[i] && !mP[i]) pick = i;
      if (pick < 0) for (int i = N - 1; i >= 0; i--) if (!mP[i]) pick = i;
      if (pick < 0) eDone = 0;
      else begin eIdx = pick; arm[pick] = 1; end
    end else if (cmd == 2) begin
      if (ri < N && mP[ri]) fill[ri] = 1;
    end else if (cmd == 3) begin
      for (int i = N - 1; i >= 0; i--) if (mV[i] && mA[i] == longint'(a)) pick = i;
      if (pick >= 0) begin eHit = 1; eKey = mK[pick]; eIdx = pick; kill[pick] = 1; end
    end else if (cmd == 4) begin
      for (int i = 0; i < N; i++) if ((mV[i] || mP[i]) && mA[i] == longint'(a)) kill[i] = 1;
    end
    #1;
    compared++;
    if (done !== eDone || hit !== eHit || longint'(keyOut) !== eKey || int'(entryIdx) !== eIdx) begin
      mismatched++;
      $display("FAIL %s cmd=%0d addr=%h: done/hit/key/idx actual %0b/%0b/%h/%0d expected %0b/%0b/%h/%0d",
               tag, cmd, a, done, hit, keyOut, entryIdx, eDone, eHit, eKey, eIdx);
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      expd[i] = mV[i] && (mAge[i] == LIMIT - 1);
      if (arm[i] || fill[i] || kill[i] || !mV[i] || expd[i]) mAge[i] = 0;
      else mAge[i] = mAge[i] + 1;
      if (arm[i]) begin mA[i] = longint'(a); mP[i] = 1; mV[i] = 0; end
      else if (fill[i]) begin mK[i] = longint'(k); mV[i] = 1; mP[i] = 0; end
      else if (kill[i]) begin mV[i] = 0; mP[i] = 0; end
      else if (expd[i]) mV[i] = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    step("R1", 3, A0, 0, 0);
    step("R1", 3, A1, 0, 0);

    // R2/R3/R4 basic reservation and consumption
    step("R2", 1, A0, 0, 0);
    step("R4", 3, A0, 0, 0);           // pending: no hit
    step("R3", 2, 0, 32'hCAFE_0001, 0);
    step("R4", 3, A0, 0, 0);           // hit, key
    step("R4", 3, A0, 0, 0);           // consumed

    // R5 store to same address cancels, other address does not
    step("R2", 1, A0, 0, 0);
    step("R3", 2, 0, 32'h1111_2222, 0);
    step("R5", 4, A0, 0, 0);
    step("R5", 3, A0, 0, 0);
    step("R2", 1, A0, 0, 0);
    step("R3", 2, 0, 32'h3333_4444, 0);
    step("R5", 4, A1, 0, 0);
    step("R5", 3, A0, 0, 0);

    // R2 two entries, R2 refusal when all pending, reuse of a pending entry
    step("R2", 1, A0, 0, 0);
    step("R2", 1, A1, 0, 0);
    step("R2", 1, A2, 0, 0);           // refused
    step("R2", 1, A1, 0, 0);           // reuse idx1
    step("R3", 2, 0, 32'hAAAA_0001, 1);
    step("R3", 2, 0, 32'hBBBB_0000, 0);
    step("R3", 2, 0, 32'hDEAD_0000, 1); // not pending: ignored
    step("R4", 3, A1, 0, 0);
    step("R4", 3, A0, 0, 0);

    // R2 eviction of lowest valid entry
    step("R2", 1, A0, 0, 0);
    step("R2", 1, A1, 0, 0);
    step("R3", 2, 0, 32'h0000_00A0, 0);
    step("R3", 2, 0, 32'h0000_00A1, 1);
    step("R2", 1, A2, 0, 0);           // evicts idx0
    step("R2", 3, A0, 0, 0);
    step("R4", 3, A1, 0, 0);
    step("R3", 2, 0, 32'h0000_00A2, 0);
    step("R4", 3, A2, 0, 0);

    // R5 store kills a pending entry; later response ignored
    step("R2", 1, A1, 0, 0);
    step("R5", 4, A1, 0, 0);
    step("R3", 2, 0, 32'h5555_5555, 0);
    step("R5", 3, A1, 0, 0);

    // R6 aging: hit on the LIMIT-th cycle after the response
    step("R2", 1, A0, 0, 0);
    step("R3", 2, 0, 32'h6666_0001, 0);
    for (int i = 0; i < LIMIT - 1; i++) step("R6", 0, 0, 0, 0);
    step("R6", 3, A0, 0, 0);
    step("R2", 1, A0, 0, 0);
    step("R3", 2, 0, 32'h6666_0002, 0);
    for (int i = 0; i < LIMIT; i++) step("R6", (i % 2 == 0) ? 0 : 5, 0, 0, 0);
    step("R6", 3, A0, 0, 0);

    // R7 R8 reserved codes act as no-op
    step("R7", 6, A0, 0, 0);
    step("R8", 7, A1, 32'hFFFF_FFFF, 1);

    // random mix compared against the model
    for (int n = 0; n < 600; n++) begin
      int c, s;
      logic [AW-1:0] ad;
      c = $urandom_range(0, 6);
      s = $urandom_range(0, 2);
      ad = (s == 0) ? A0 : (s == 1) ? A1 : A2;
      step("RND", c, ad, KW'($urandom), $urandom_range(0, 1));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule